// File: doc/BRIEF.md
# Divider-Driven Sound Frame Sequencer

This block produces the slow timing strobes that a sound unit's channels use for their length counters, their frequency sweep and their volume envelopes. It has no prescaler of its own. It watches one bit of a free-running system divider and takes one step each time that bit falls from 1 to 0. With the usual divider this gives a nominal step rate of 512 Hz. In double-speed mode the divider runs twice as fast, so the block watches the next higher bit and the step rate stays the same.

A 3-bit step count decides which strobes a step emits:

| Strobe | Steps that emit it | Nominal rate |
|---|---|---|
| Length | 0, 2, 4, 6 | 256 Hz |
| Sweep | 2, 6 | 128 Hz |
| Envelope | 7 | 64 Hz |

Each strobe is a pulse one clock wide. Software can clear the divider. If it does so while the watched bit is 1, the block counts that write as a falling edge, so software can insert extra steps. Turning the sound unit off holds the count at zero and blocks every strobe.

Top module: `sfs_frame_seq`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is asserted, `step_o` is 0 and all three tick outputs are 0.
- R2: With `fast_i` = 0 the block watches `div_i[4]`. A cycle in which that bit reads 0 after it read 1 in the previous cycle advances `step_o` by one, modulo 8. The new value is visible after the next rising clock edge.
- R3: With `fast_i` = 1 the block watches `div_i[5]`. Changes on `div_i[4]` then cause no step.
- R4: A cycle with `div_wr_i` = 1 while the watched bit reads 1 advances the step once. The divider reading 0 in the next cycle does not count a second time. A write while the watched bit reads 0 causes no step.
- R5: A step taken from step value 0, 2, 4 or 6 raises `len_tick_o` for exactly one cycle, in the same cycle that the new `step_o` appears.
- R6: A step taken from step value 2 or 6 raises `swp_tick_o` for one cycle, alongside `len_tick_o`.
- R7: A step taken from step value 7 raises `env_tick_o` for one cycle, and `step_o` wraps to 0.
- R8: A tick output is high only in the cycle right after a step. Over 16 consecutive steps the block emits 8 length ticks, 4 sweep ticks and 2 envelope ticks.
- R9: While `snd_en_i` = 0, `step_o` is forced to 0 and no tick is emitted. Divider edges in that time are discarded. After `snd_en_i` returns to 1, counting restarts from step 0.
- R10: In a cycle where `fast_i` differs from its value in the previous cycle, no step is taken, even if the newly selected bit reads 0 and the old one read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snd_en_i | input | 1 | Sound unit powered; 0 holds the sequencer at step 0 |
| div_i | input | 16 | Current value of the free-running system divider |
| fast_i | input | 1 | Double-speed mode; selects the higher watched bit |
| div_wr_i | input | 1 | Strobe: the divider is cleared at the end of this cycle |
| len_tick_o | output | 1 | Length counter strobe, one cycle wide |
| swp_tick_o | output | 1 | Frequency sweep strobe, one cycle wide |
| env_tick_o | output | 1 | Volume envelope strobe, one cycle wide |
| step_o | output | 3 | Current step count |

## Verification
The hardest situations to reach are the ones where a divider write or a speed change arrives at the same moment as a level on the watched bit. These could cause a double count or a false step, and a free-running divider almost never lines them up. The bench therefore drives the divider bits cycle by cycle from a vector table, using these sequences:

- a write with the bit high, then the bit low;
- a write with the bit already low;
- a speed switch while the old bit is high and the new bit is low.

It then lets a real counting divider run through complete 8-step cycles in both speed modes and counts the strobes.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   // Grouped strobe set issued after one step
   typedef struct packed {
      logic len;
      logic swp;
      logic env;
   } sfs_tick_t;

   localparam int SFS_NUM_EVENTS = 3;

   function automatic bit sfs_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sfs_div_edge.sv
module sfs_div_edge #(
   parameter int DIV_W    = 16,
   parameter int NORM_BIT = 4,
   parameter int FAST_BIT = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             fast_i,
   input  logic             div_wr_i,
   output logic             fall_o
);

   logic watched;
   logic prev_q;
   logic fast_q;
   logic mode_chg;

   generate
      if (NORM_BIT == FAST_BIT) begin : g_single_bit
         assign watched = div_i[NORM_BIT];
      end else begin : g_sel_bit
         assign watched = fast_i ? div_i[FAST_BIT] : div_i[NORM_BIT];
      end
   endgenerate

   // A speed switch moves the watched bit; that cycle must not be read as an edge
   assign mode_chg = (fast_i != fast_q);

   assign fall_o = !mode_chg &&
                   ((prev_q && !watched) || (div_wr_i && watched));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         fast_q <= 1'b0;
      end else begin
         fast_q <= fast_i;
         // a divider write clears the bit, so the next sample starts from 0
         prev_q <= div_wr_i ? 1'b0 : watched;
      end
   end

endmodule

// File: rtl/sfs_step_ctr.sv
module sfs_step_ctr #(
   parameter int STEP_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              adv_i,
   output logic [STEP_W-1:0] step_o
);

   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_q <= '0;
      end else if (!en_i) begin
         step_q <= '0;
      end else if (adv_i) begin
         step_q <= step_q + 1'b1;
      end
   end

   assign step_o = step_q;

endmodule

// File: rtl/sfs_tick_dec.sv
module sfs_tick_dec #(
   parameter int STEP_W = 3,
   parameter int EVERY  = 2,
   parameter int PHASE  = 0
) (
   input  logic [STEP_W-1:0] step_i,
   output logic              hit_o
);

   localparam logic [STEP_W-1:0] MASK = STEP_W'(EVERY - 1);
   localparam logic [STEP_W-1:0] PH   = STEP_W'(PHASE);

   generate
      if (EVERY == 1) begin : g_every_step
         assign hit_o = 1'b1;
      end else begin : g_masked
         assign hit_o = ((step_i & MASK) == PH);
      end
   endgenerate

endmodule

// File: rtl/sfs_frame_seq.sv
module sfs_frame_seq #(
   parameter int DIV_W     = 16,
   parameter int NORM_BIT  = 4,
   parameter int FAST_BIT  = 5,
   parameter int STEP_W    = 3,
   parameter int LEN_EVERY = 2,
   parameter int LEN_PHASE = 0,
   parameter int SWP_EVERY = 4,
   parameter int SWP_PHASE = 2,
   parameter int ENV_EVERY = 8,
   parameter int ENV_PHASE = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              snd_en_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              fast_i,
   input  logic              div_wr_i,
   output logic              len_tick_o,
   output logic              swp_tick_o,
   output logic              env_tick_o,
   output logic [STEP_W-1:0] step_o
);

   import sfs_pkg::*;

   localparam int STEPS = 1 << STEP_W;

   // Elaboration-time parameter checks
   generate
      if (NORM_BIT >= DIV_W || FAST_BIT >= DIV_W) begin : g_bad_bit
         $error("watched divider bit outside divider width");
      end
      if (!sfs_is_pow2(LEN_EVERY) || LEN_EVERY > STEPS || LEN_PHASE >= LEN_EVERY) begin : g_bad_len
         $error("length schedule does not fit the step counter");
      end
      if (!sfs_is_pow2(SWP_EVERY) || SWP_EVERY > STEPS || SWP_PHASE >= SWP_EVERY) begin : g_bad_swp
         $error("sweep schedule does not fit the step counter");
      end
      if (!sfs_is_pow2(ENV_EVERY) || ENV_EVERY > STEPS || ENV_PHASE >= ENV_EVERY) begin : g_bad_env
         $error("envelope schedule does not fit the step counter");
      end
   endgenerate

   logic              fall;
   logic [STEP_W-1:0] step;
   sfs_tick_t         hit;
   sfs_tick_t         tick_q;

   sfs_div_edge #(
      .DIV_W   (DIV_W),
      .NORM_BIT(NORM_BIT),
      .FAST_BIT(FAST_BIT)
   ) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .div_i   (div_i),
      .fast_i  (fast_i),
      .div_wr_i(div_wr_i),
      .fall_o  (fall)
   );

   sfs_step_ctr #(.STEP_W(STEP_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (snd_en_i),
      .adv_i (fall),
      .step_o(step)
   );

   sfs_tick_dec #(.STEP_W(STEP_W), .EVERY(LEN_EVERY), .PHASE(LEN_PHASE)) u_dec_len (
      .step_i(step), .hit_o(hit.len)
   );
   sfs_tick_dec #(.STEP_W(STEP_W), .EVERY(SWP_EVERY), .PHASE(SWP_PHASE)) u_dec_swp (
      .step_i(step), .hit_o(hit.swp)
   );
   sfs_tick_dec #(.STEP_W(STEP_W), .EVERY(ENV_EVERY), .PHASE(ENV_PHASE)) u_dec_env (
      .step_i(step), .hit_o(hit.env)
   );

   // Strobes are decoded from the step being left and registered with the advance
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_q <= '0;
      end else if (!snd_en_i || !fall) begin
         tick_q <= '0;
      end else begin
         tick_q <= hit;
      end
   end

   assign len_tick_o = tick_q.len;
   assign swp_tick_o = tick_q.swp;
   assign env_tick_o = tick_q.env;
   assign step_o     = step;

endmodule

// File: rtl/sfs_frame_seq_chk.sv
module sfs_frame_seq_chk #(
   parameter int STEP_W    = 3,
   parameter int LEN_EVERY = 2,
   parameter int LEN_PHASE = 0,
   parameter int SWP_EVERY = 4,
   parameter int SWP_PHASE = 2,
   parameter int ENV_EVERY = 8,
   parameter int ENV_PHASE = 7
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              snd_en_i,
   input logic              len_tick_o,
   input logic              swp_tick_o,
   input logic              env_tick_o,
   input logic [STEP_W-1:0] step_o
);

   localparam logic [STEP_W-1:0] LEN_MASK = STEP_W'(LEN_EVERY - 1);
   localparam logic [STEP_W-1:0] SWP_MASK = STEP_W'(SWP_EVERY - 1);
   localparam logic [STEP_W-1:0] ENV_MASK = STEP_W'(ENV_EVERY - 1);

   logic              any_tick;
   logic [STEP_W-1:0] step_prev;

   assign any_tick  = len_tick_o | swp_tick_o | env_tick_o;
   assign step_prev = STEP_W'(step_o - 1'b1);

   a_r1_reset_quiet: assert property (@(posedge clk_i)
      !rst_ni |=> (step_o == '0 && !any_tick));

   a_r2_step_plus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snd_en_i |=> (step_o == $past(step_o) || step_o == STEP_W'($past(step_o) + 1'b1)));

   a_r5_len_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      len_tick_o |-> ((step_prev & LEN_MASK) == STEP_W'(LEN_PHASE)));

   a_r6_swp_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swp_tick_o |-> ((step_prev & SWP_MASK) == STEP_W'(SWP_PHASE)));

   a_r7_env_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      env_tick_o |-> ((step_prev & ENV_MASK) == STEP_W'(ENV_PHASE)));

   a_r8_tick_with_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_tick |-> (step_o != $past(step_o)));

   a_r9_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !snd_en_i |=> (step_o == '0 && !any_tick));

   generate
      if (LEN_EVERY > 1) begin : g_len_single
         a_r8_len_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
            len_tick_o |=> !len_tick_o);
      end
   endgenerate

endmodule

bind sfs_frame_seq sfs_frame_seq_chk #(
   .STEP_W   (STEP_W),
   .LEN_EVERY(LEN_EVERY),
   .LEN_PHASE(LEN_PHASE),
   .SWP_EVERY(SWP_EVERY),
   .SWP_PHASE(SWP_PHASE),
   .ENV_EVERY(ENV_EVERY),
   .ENV_PHASE(ENV_PHASE)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .snd_en_i  (snd_en_i),
   .len_tick_o(len_tick_o),
   .swp_tick_o(swp_tick_o),
   .env_tick_o(env_tick_o),
   .step_o    (step_o)
);

// File: tb/test_sfs_frame_seq.sv
module test_sfs_frame_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 26;

   // Vector fields: [14:11] req, [10] bit4, [9] bit5, [8] fast, [7] wr, [6] en,
   //                [5:3] expected step, [2] len, [1] swp, [0] env
   localparam logic [14:0] VEC [0:NVEC-1] = '{
      15'b0010_10001_000_000,  // R2 bit4 high, no edge yet
      15'b0101_00001_001_100,  // R5 edge from step 0
      15'b0010_10001_001_000,  // R2
      15'b0010_00001_010_000,  // R2 edge from step 1, no tick
      15'b0010_10001_010_000,  // R2
      15'b0110_00001_011_110,  // R6 edge from step 2
      15'b0100_10011_100_000,  // R4 write with bit high -> extra step
      15'b0100_00001_100_000,  // R4 cleared bit not counted again
      15'b0100_00011_100_000,  // R4 write with bit low -> nothing
      15'b0010_10001_100_000,  // R2
      15'b0101_00001_101_100,  // R5 edge from step 4
      15'b0010_10001_101_000,  // R2
      15'b0010_00001_110_000,  // R2
      15'b0010_10001_110_000,  // R2
      15'b0110_00001_111_110,  // R6 edge from step 6
      15'b0010_10001_111_000,  // R2
      15'b0111_00001_000_001,  // R7 edge from step 7, wrap
      15'b1010_11101_000_000,  // R10 switch to fast
      15'b0011_01101_000_000,  // R3 bit4 falls, ignored in fast mode
      15'b0011_00101_001_100,  // R3 bit5 falls
      15'b0011_11101_001_000,  // R3
      15'b1010_00001_001_000,  // R10 switch back with bit5 high, bit4 low: no step
      15'b1001_10000_000_000,  // R9 power off forces step 0
      15'b1001_00000_000_000,  // R9 edge while off ignored
      15'b1001_10001_000_000,  // R9 power on
      15'b1001_00001_001_100   // R9 counting restarts from 0
   };

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        snd_en_i = 1'b1;
   logic [15:0] div_i = '0;
   logic        fast_i = 1'b0;
   logic        div_wr_i = 1'b0;
   logic        len_tick_o;
   logic        swp_tick_o;
   logic        env_tick_o;
   logic [2:0]  step_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk_i = ~clk_i;

   sfs_frame_seq i_sfs_frame_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .snd_en_i  (snd_en_i),
      .div_i     (div_i),
      .fast_i    (fast_i),
      .div_wr_i  (div_wr_i),
      .len_tick_o(len_tick_o),
      .swp_tick_o(swp_tick_o),
      .env_tick_o(env_tick_o),
      .step_o    (step_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int outs();
      return {26'd0, step_o, len_tick_o, swp_tick_o, env_tick_o};
   endfunction

   task automatic free_run(input logic fast, input int exp_len, input int exp_swp,
                           input int exp_env, input string tag);
      int c_len = 0;
      int c_swp = 0;
      int c_env = 0;
      int dbl   = 0;
      logic prev_len = 1'b0;
      @(negedge clk_i);
      rst_ni = 1'b0; fast_i = fast; snd_en_i = 1'b1; div_wr_i = 1'b0; div_i = '0;
      @(negedge clk_i);
      rst_ni = 1'b1;
      for (int cnt = 0; cnt < 520; cnt++) begin
         div_i = 16'(cnt);
         @(negedge clk_i);
         c_len += int'(len_tick_o);
         c_swp += int'(swp_tick_o);
         c_env += int'(env_tick_o);
         if (prev_len && len_tick_o) dbl++;
         prev_len = len_tick_o;
      end
      check({"R8 len count ", tag}, c_len, exp_len);
      check({"R6 swp count ", tag}, c_swp, exp_swp);
      check({"R7 env count ", tag}, c_env, exp_env);
      check({"R8 len pulse width ", tag}, dbl, 0);
      check({"R2 final step ", tag}, int'(step_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      // R1: state during reset
      check("R1 reset outputs", outs(), 0);
      rst_ni = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         div_i    = 16'({VEC[i][9], VEC[i][10], 4'b0000});
         fast_i   = VEC[i][8];
         div_wr_i = VEC[i][7];
         snd_en_i = VEC[i][6];
         @(negedge clk_i);
         check($sformatf("R%0d row %0d", VEC[i][14:11], i), outs(), int'(VEC[i][5:0]));
      end
      div_wr_i = 1'b0;
      check("R1 nonzero before reset", int'(step_o), 1);
      rst_ni = 1'b0;
      #1;
      check("R1 asynchronous reset", outs(), 0);
      // R2, R5, R6, R7, R8: 16 steps in normal speed
      free_run(1'b0, 8, 4, 2, "normal");
      // R3: 8 steps in double speed
      free_run(1'b1, 4, 2, 1, "fast");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule